// File: doc/BRIEF.md
# Interrupt Coalescing Counter and Delay Timer

This block moderates the interrupt rate of one data-movement channel. It counts finished packets against a programmable threshold and raises a completion flag only when that many packets have finished. Alongside the counter runs a one-shot inactivity timer that is re-armed by every packet completion. When the timer runs out, the block raises a delay flag so that a trickle of packets below the threshold still gets serviced. Timer expiry also rewinds the packet counter to the threshold.

A third flag records a channel fault. Each flag stays set until software clears it with a pulse. The interrupt line is the OR of the pending flags, each masked by its own enable bit. The configuration fields (threshold, delay, enables) are plain inputs driven from a control register kept outside the block. A control-write pulse tells the block that the control register was written. A tick-enable input, divided by a parameterised prescaler, paces the timer.

The timer is a two-state machine. TMR_IDLE holds a count of zero. The transition named arm moves TMR_IDLE to TMR_RUN when a packet completes while the delay field is nonzero. The transition named rearm keeps TMR_RUN and reloads the count on a further such completion. The transition named expire returns TMR_RUN to TMR_IDLE on the prescaled tick that takes the count from 1 to 0.

Top module: `irq_coal_unit`

## Requirements
- R1: Out of reset the flags are all zero, the packet count is 1, the timer count is 0 and irq is low.
- R2: A cycle with cfg_wr high loads the packet count from cfg_thresh. A completion in the same cycle is not counted and sets no flag.
- R3: A completion without cfg_wr decrements the packet count. When the count is 1 at that completion, flags[0] (completion) is set and the count reloads from cfg_thresh.
- R4: A threshold of 0 stands for 256 packets. A completion at count 0 moves the count to 255 (all ones) and sets no flag.
- R5: A completion while cfg_delay is nonzero loads the timer with cfg_delay, even when the timer is already running. A completion with cfg_delay zero leaves the timer untouched.
- R6: The prescaler counts cycles with tick_en high. Every PRESCALE such cycles (default 4) it emits one tick, and each tick lowers a nonzero timer count by one. The prescaler is never restarted by a load.
- R7: The tick that takes the timer from 1 to 0 sets flags[1] (delay) and reloads the packet count from cfg_thresh, overriding a decrement in that cycle. Afterwards the timer stays at 0 until the next load. A load in the same cycle cancels the expiry.
- R8: fault_set sets flags[2] (fault).
- R9: A high bit of flag_clr clears the flag at the same position. If a set and a clear of one flag meet in a cycle, the flag ends up set.
- R10: irq is high exactly when some bit i has both flags[i] and cfg_irq_en[i] high (bit 0 completion, bit 1 delay, bit 2 fault).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_thresh | input | CNT_W | Packet threshold; 0 means 256 |
| cfg_delay | input | DLY_W | Inactivity delay in ticks; 0 disables re-arming |
| cfg_irq_en | input | 3 | Per-flag interrupt enables |
| cfg_wr | input | 1 | Pulse: control register written |
| pkt_done | input | 1 | Pulse: one packet finished |
| tick_en | input | 1 | Timebase enable fed to the prescaler |
| fault_set | input | 1 | Pulse: set the fault flag |
| flag_clr | input | 3 | Per-flag clear pulses |
| flags | output | 3 | Pending flags: completion, delay, fault |
| pend_count | output | CNT_W | Live packet count |
| delay_count | output | DLY_W | Live timer count |
| irq | output | 1 | Interrupt line |

## Verification
The assertions assume that the inputs change only between clock edges and are free of X. They also assume that pkt_done, cfg_wr, fault_set and flag_clr may occur in any combination in one cycle, so every property is written with the priority rules in R2, R7 and R9 built in. The stimulus drives all inputs on the falling edge. It mixes directed sequences with seeded random traffic in which completions, clears, faults and control writes coincide freely. Thresholds and delays are kept small so that expiries and threshold hits happen often.

// File: rtl/irq_coal_pkg.sv
package irq_coal_pkg;
    localparam int NFLAG     = 3;
    localparam int FLG_DONE  = 0;
    localparam int FLG_DLY   = 1;
    localparam int FLG_FAULT = 2;

    typedef enum logic {
        TMR_IDLE = 1'b0,
        TMR_RUN  = 1'b1
    } tmr_state_e;
endpackage

// File: rtl/irq_coal_prescaler.sv
module irq_coal_prescaler #(
    parameter int PRESCALE = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_en,
    output logic tick
);
    generate
        if (PRESCALE <= 1) begin : g_bypass
            assign tick = tick_en;
        end else begin : g_div
            localparam int PW = $clog2(PRESCALE);
            localparam logic [PW-1:0] LAST = PW'(PRESCALE - 1);
            logic [PW-1:0] pre_q;

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    pre_q <= '0;
                end else if (tick_en) begin
                    pre_q <= (pre_q == LAST) ? '0 : pre_q + 1'b1;
                end
            end

            assign tick = tick_en && (pre_q == LAST);
        end
    endgenerate
endmodule

// File: rtl/irq_coal_delay_timer.sv
module irq_coal_delay_timer
    import irq_coal_pkg::*;
#(
    parameter int DLY_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [DLY_W-1:0] delay_val,
    input  logic             tick,
    output logic [DLY_W-1:0] count,
    output logic             expire
);
    localparam logic [DLY_W-1:0] ONE = DLY_W'(1);

    tmr_state_e       state_q, state_d;
    logic [DLY_W-1:0] cnt_q, cnt_d;
    logic             load;

    assign load = restart && (delay_val != '0);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TMR_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // next state: arm, rearm, expire
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TMR_IDLE: if (load) state_d = TMR_RUN;
            TMR_RUN: begin
                if (load)                          state_d = TMR_RUN;
                else if (tick && (cnt_q == ONE))   state_d = TMR_IDLE;
            end
            default: state_d = TMR_IDLE;
        endcase
    end

    // outputs and datapath
    always_comb begin
        cnt_d  = cnt_q;
        expire = 1'b0;
        unique case (state_q)
            TMR_IDLE: begin
                if (load) cnt_d = delay_val;
            end
            TMR_RUN: begin
                if (load) begin
                    cnt_d = delay_val;
                end else if (tick) begin
                    cnt_d  = cnt_q - ONE;
                    expire = (cnt_q == ONE);
                end
            end
            default: cnt_d = '0;
        endcase
    end

    assign count = cnt_q;
endmodule

// File: rtl/irq_coal_pkt_counter.sv
module irq_coal_pkt_counter #(
    parameter int CNT_W        = 8,
    parameter int RESET_THRESH = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reload_req,
    input  logic             done,
    input  logic             expire,
    input  logic [CNT_W-1:0] thresh,
    output logic [CNT_W-1:0] count,
    output logic             fire
);
    localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);
    localparam logic [CNT_W-1:0] RST_VAL = CNT_W'(RESET_THRESH);

    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_comb begin
        fire = done && !reload_req && (cnt_q == ONE);
        if (reload_req || fire || expire) begin
            cnt_d = thresh;
        end else if (done) begin
            cnt_d = cnt_q - ONE;
        end else begin
            cnt_d = cnt_q;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= RST_VAL;
        else        cnt_q <= cnt_d;
    end

    assign count = cnt_q;
endmodule

// File: rtl/irq_coal_flag_bank.sv
module irq_coal_flag_bank #(
    parameter int NF = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NF-1:0] set,
    input  logic [NF-1:0] clr,
    input  logic [NF-1:0] en,
    output logic [NF-1:0] flags,
    output logic          irq
);
    logic [NF-1:0] flags_q;

    generate
        for (genvar i = 0; i < NF; i++) begin : g_flag
            always_ff @(posedge clk) begin
                if (!rst_n)      flags_q[i] <= 1'b0;
                else if (set[i]) flags_q[i] <= 1'b1;
                else if (clr[i]) flags_q[i] <= 1'b0;
            end
        end
    endgenerate

    assign flags = flags_q;
    assign irq   = |(flags_q & en);
endmodule

// File: rtl/irq_coal_unit.sv
module irq_coal_unit
    import irq_coal_pkg::*;
#(
    parameter int CNT_W        = 8,
    parameter int DLY_W        = 8,
    parameter int PRESCALE     = 4,
    parameter int RESET_THRESH = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cfg_thresh,
    input  logic [DLY_W-1:0] cfg_delay,
    input  logic [NFLAG-1:0] cfg_irq_en,
    input  logic             cfg_wr,
    input  logic             pkt_done,
    input  logic             tick_en,
    input  logic             fault_set,
    input  logic [NFLAG-1:0] flag_clr,
    output logic [NFLAG-1:0] flags,
    output logic [CNT_W-1:0] pend_count,
    output logic [DLY_W-1:0] delay_count,
    output logic             irq
);
    logic             tick;
    logic             expire;
    logic             fire;
    logic [NFLAG-1:0] set_vec;

    irq_coal_prescaler #(.PRESCALE(PRESCALE)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (tick_en),
        .tick    (tick)
    );

    irq_coal_delay_timer #(.DLY_W(DLY_W)) u_tmr (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (pkt_done),
        .delay_val (cfg_delay),
        .tick      (tick),
        .count     (delay_count),
        .expire    (expire)
    );

    irq_coal_pkt_counter #(.CNT_W(CNT_W), .RESET_THRESH(RESET_THRESH)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .reload_req (cfg_wr),
        .done       (pkt_done),
        .expire     (expire),
        .thresh     (cfg_thresh),
        .count      (pend_count),
        .fire       (fire)
    );

    always_comb begin
        set_vec            = '0;
        set_vec[FLG_DONE]  = fire;
        set_vec[FLG_DLY]   = expire;
        set_vec[FLG_FAULT] = fault_set;
    end

    irq_coal_flag_bank #(.NF(NFLAG)) u_flg (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (set_vec),
        .clr   (flag_clr),
        .en    (cfg_irq_en),
        .flags (flags),
        .irq   (irq)
    );
endmodule

// File: rtl/irq_coal_chk.sv
module irq_coal_chk
    import irq_coal_pkg::*;
#(
    parameter int CNT_W        = 8,
    parameter int DLY_W        = 8,
    parameter int PRESCALE     = 4,
    parameter int RESET_THRESH = 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CNT_W-1:0] cfg_thresh,
    input logic [DLY_W-1:0] cfg_delay,
    input logic [NFLAG-1:0] cfg_irq_en,
    input logic             cfg_wr,
    input logic             pkt_done,
    input logic             tick_en,
    input logic             fault_set,
    input logic [NFLAG-1:0] flag_clr,
    input logic [NFLAG-1:0] flags,
    input logic [CNT_W-1:0] pend_count,
    input logic [DLY_W-1:0] delay_count,
    input logic             irq
);
    a_r2_write_reload: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> pend_count == $past(cfg_thresh));

    a_r3_threshold_hit: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_done && !cfg_wr && pend_count == CNT_W'(1)
        |=> flags[FLG_DONE] && pend_count == $past(cfg_thresh));

    a_r4_zero_wraps: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_done && !cfg_wr && pend_count == '0 && delay_count == '0
        |=> pend_count == {CNT_W{1'b1}} && !$rose(flags[FLG_DONE]));

    a_r5_timer_load: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_done && cfg_delay != '0 |=> delay_count == $past(cfg_delay));

    a_r6_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        delay_count != '0 && !(pkt_done && cfg_delay != '0)
        |=> delay_count == $past(delay_count) || delay_count == $past(delay_count) - DLY_W'(1));

    a_r7_one_shot: assert property (@(posedge clk) disable iff (!rst_n)
        delay_count == '0 && !(pkt_done && cfg_delay != '0) |=> delay_count == '0);

    a_r7_expiry_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags[FLG_DLY]) |-> $past(delay_count) == DLY_W'(1));

    a_r9_fault_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        fault_set |=> flags[FLG_FAULT]);

    a_r10_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (flags & cfg_irq_en) == '0 |-> !irq);

    a_r10_irq_raised: assert property (@(posedge clk) disable iff (!rst_n)
        (flags & cfg_irq_en) != '0 |-> irq);
endmodule

bind irq_coal_unit irq_coal_chk #(
    .CNT_W(CNT_W), .DLY_W(DLY_W), .PRESCALE(PRESCALE), .RESET_THRESH(RESET_THRESH)
) u_chk (.*);

// File: tb/irq_coal_unit_bench.sv
`timescale 1ns/1ps
module irq_coal_unit_bench;
    localparam int CNT_W    = 8;
    localparam int DLY_W    = 8;
    localparam int PRESCALE = 4;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic             rst_n;
    logic [CNT_W-1:0] d_thresh;
    logic [DLY_W-1:0] d_delay;
    logic [2:0]       d_en;
    logic             d_wr, d_pkt, d_tick, d_fault;
    logic [2:0]       d_clr;
    logic [2:0]       flags;
    logic [CNT_W-1:0] pend_count;
    logic [DLY_W-1:0] delay_count;
    logic             irq;

    irq_coal_unit #(.CNT_W(CNT_W), .DLY_W(DLY_W), .PRESCALE(PRESCALE)) u_irq_coal_unit (
        .clk(clk), .rst_n(rst_n), .cfg_thresh(d_thresh), .cfg_delay(d_delay),
        .cfg_irq_en(d_en), .cfg_wr(d_wr), .pkt_done(d_pkt), .tick_en(d_tick),
        .fault_set(d_fault), .flag_clr(d_clr), .flags(flags),
        .pend_count(pend_count), .delay_count(delay_count), .irq(irq)
    );

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // reference state
    logic [CNT_W-1:0] m_cnt;
    logic [DLY_W-1:0] m_tmr;
    int               m_pre;
    logic [2:0]       m_flags;

    task automatic chk(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic logic exp_irq();
        return |(m_flags & d_en);
    endfunction

    task automatic compare(string tag);
        chk(tag, "pend_count", int'(pend_count), int'(m_cnt));
        chk(tag, "delay_count", int'(delay_count), int'(m_tmr));
        chk(tag, "flags", int'(flags), int'(m_flags));
        chk(tag, "irq", int'(irq), int'(exp_irq()));
    endtask

    // called at a falling edge: drive, advance reference, sample at next falling edge
    task automatic step(string tag, logic pkt, logic wr, logic tk_en, logic flt, logic [2:0] clr);
        logic tk, load, expire, fire;
        logic [CNT_W-1:0] n_cnt;
        logic [DLY_W-1:0] n_tmr;
        int n_pre;
        d_pkt = pkt; d_wr = wr; d_tick = tk_en; d_fault = flt; d_clr = clr;
        tk     = tk_en && (m_pre == PRESCALE - 1);
        n_pre  = tk_en ? (tk ? 0 : m_pre + 1) : m_pre;
        load   = pkt && (d_delay != '0);
        expire = !load && tk && (m_tmr == DLY_W'(1));
        n_tmr  = load ? d_delay : ((tk && m_tmr != '0) ? m_tmr - 1'b1 : m_tmr);
        fire   = pkt && !wr && (m_cnt == CNT_W'(1));
        n_cnt  = (wr || fire || expire) ? d_thresh : (pkt ? m_cnt - 1'b1 : m_cnt);
        @(posedge clk);
        @(negedge clk);
        m_pre   = n_pre;
        m_tmr   = n_tmr;
        m_cnt   = n_cnt;
        m_flags = (m_flags & ~clr) | {flt, expire, fire};
        compare(tag);
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        rst_n = 1'b0;
        d_thresh = 8'd1; d_delay = '0; d_en = 3'b000;
        d_wr = 0; d_pkt = 0; d_tick = 0; d_fault = 0; d_clr = 0;
        m_cnt = 8'd1; m_tmr = '0; m_pre = 0; m_flags = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        compare("R1 reset");

        // R2: control write with a simultaneous completion
        d_thresh = 8'd3;
        step("R2 write plus completion", 1, 1, 0, 0, 3'b000);

        // R3: three completions reach threshold
        for (int i = 0; i < 3; i++) step("R3 count to threshold", 1, 0, 0, 0, 3'b000);

        // R9: set beats clear, then a clear alone
        d_thresh = 8'd1;
        step("R9 reload to one", 0, 1, 0, 0, 3'b000);
        step("R9 set wins over clear", 1, 0, 0, 0, 3'b001);
        step("R9 clear alone", 0, 0, 0, 0, 3'b001);

        // R4: threshold zero needs 256 completions
        d_thresh = 8'd0;
        step("R4 load zero", 0, 1, 0, 0, 3'b000);
        for (int i = 0; i < 256; i++) step("R4 wrap through 256", 1, 0, 0, 0, 3'b000);

        // R5: load, rearm, and zero-delay completion
        d_thresh = 8'd50;
        step("R5 setup", 0, 1, 0, 0, 3'b001);
        d_delay = 8'd5;
        step("R5 arm", 1, 0, 0, 0, 3'b000);
        for (int i = 0; i < 6; i++) step("R6 prescaled ticks", 0, 0, 1, 0, 3'b000);
        step("R5 rearm", 1, 0, 0, 0, 3'b000);
        d_delay = 8'd0;
        step("R5 zero delay keeps timer", 1, 0, 1, 0, 3'b000);

        // R6/R7: run to expiry and stay idle
        for (int i = 0; i < 30; i++) step("R7 expiry and one shot", 0, 0, 1, 0, 3'b000);

        // R8 fault flag, R10 enables
        step("R8 fault set", 0, 0, 0, 1, 3'b000);
        for (int e = 0; e < 8; e++) begin
            d_en = 3'(e);
            step("R10 enable mask", 0, 0, 0, 0, 3'b000);
        end
        step("R10 clear all", 0, 0, 0, 0, 3'b111);

        // seeded random traffic
        for (int i = 0; i < 6000; i++) begin
            if ($urandom_range(15) == 0) begin
                d_thresh = 8'($urandom_range(0, 6));
                d_delay  = 8'($urandom_range(0, 12));
            end
            if ($urandom_range(31) == 0) d_en = 3'($urandom_range(0, 7));
            step("R10 random",
                 logic'($urandom_range(3) == 0),
                 logic'($urandom_range(15) == 0),
                 logic'($urandom_range(1)),
                 logic'($urandom_range(31) == 0),
                 {logic'($urandom_range(9) == 0), logic'($urandom_range(9) == 0),
                  logic'($urandom_range(9) == 0)});
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule